// File: doc/BRIEF.md
# Serial Bitstream Configuration Loader

This block programs a downstream configurable device through its bit-serial slave port. After a start pulse it pulls the device's program line low. It waits for the device to acknowledge by driving its init line low, then lets program go. Once init returns high, the block takes bytes from a valid/ready stream and shifts each one out most-significant bit first on a data line, with a serial clock it generates. The device samples on the rising edge of that clock.

While bytes are flowing, the block watches for the device's integrity fault: init low while done is still low. After the final byte it holds the data line high and keeps clocking until the device raises done. Every wait has a timeout, and each failure sets its own error code. The code, or the done flag, stays visible until the next start. The serial clock half-period and the timeout length are counted in system clocks and set by parameters.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, dev_prog_n is 1, dev_cclk is 0, busy, done and in_ready are 0, and err_code is 0.
- R2: A start pulse while idle sets busy and drives dev_prog_n low on the next cycle. dev_prog_n returns high only after the synchronised dev_init_n has been seen low.
- R3: If dev_init_n is not seen low within WAIT_CLKS cycles of program going low, the load ends with err_code 1 (init-start timeout).
- R4: If dev_init_n does not return high within WAIT_CLKS cycles of program being released, the load ends with err_code 2 (init-clear timeout).
- R5: No serial clock edge and no byte acceptance happen while program is asserted or before init has returned high.
- R6: Each accepted byte is sent as 8 bits, bit 7 first and bit 0 last, with dev_din stable across each rising edge of dev_cclk. The device receives the bytes in stream order, exactly byte_total of them.
- R7: While busy, every high phase of dev_cclk lasts exactly HALF_CLKS cycles, and each low phase inside a byte lasts HALF_CLKS cycles.
- R8: in_ready is 1 only between bytes, with dev_cclk low. It drops on the cycle after a handshake and stays low while a byte is shifted.
- R9: At a byte boundary, synchronised init low with done low ends the load with err_code 3 (CRC fault), and the remaining bytes are not sent.
- R10: After the last byte, dev_din stays 1 and dev_cclk keeps toggling until dev_done is seen high. The load then ends with done=1 and err_code 0.
- R11: If dev_done is not seen high within WAIT_CLKS cycles of the trailing phase starting, the load ends with err_code 4 (done timeout).
- R12: done and err_code hold their values until the next start. A start pulse during a load has no effect. A new start clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a load |
| byte_total | input | CNT_W | Number of bytes in the bitstream, captured at start |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Block accepts in_data this cycle |
| dev_prog_n | output | 1 | Device program request, active low |
| dev_cclk | output | 1 | Serial configuration clock |
| dev_din | output | 1 | Serial configuration data |
| dev_init_n | input | 1 | Device init status, active low |
| dev_done | input | 1 | Device done status, high when configured |
| busy | output | 1 | Load in progress |
| done | output | 1 | Last load finished successfully |
| err_code | output | 3 | 0 none, 1 init-start timeout, 2 init-clear timeout, 3 CRC fault, 4 done timeout |

## Verification
Some rules are checked on every cycle: program is asserted only while busy and with the clock low, in_ready appears only between bytes and falls after each handshake, every clock high phase while busy is exactly HALF_CLKS cycles, and done and error are mutually exclusive and sticky while idle. Other behaviour only the bench scenarios can show, because it needs a device model: that the received bytes match the stream MSB-first, that the trailing data stays high, and that each timeout and the CRC fault produce their own code. The same holds for the count of bytes that reach the device after an integrity fault.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ERR_NONE       = 3'd0,
      ERR_INIT_START = 3'd1,
      ERR_INIT_CLEAR = 3'd2,
      ERR_CRC        = 3'd3,
      ERR_DONE_TMO   = 3'd4
   } cfgl_err_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_PROG,
      S_WAKE,
      S_GATE,
      S_SHIFT,
      S_TRAIL
   } cfgl_state_e;
endpackage

// File: rtl/cfgl_sync.sv
// Multi-stage synchroniser for a small bundle of asynchronous status pins.
module cfgl_sync #(
   parameter int             W       = 2,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cfgl_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgl_tick.sv
// Half-period strobe for the serial clock; restarts while clr is high.
module cfgl_tick #(
   parameter int HALF_CLKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   if (HALF_CLKS < 1) begin : g_bad_half
      $error("cfgl_tick: HALF_CLKS must be at least 1");
   end

   if (HALF_CLKS == 1) begin : g_every
      assign tick = 1'b1;
   end else begin : g_count
      localparam int CW = $clog2(HALF_CLKS);
      localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           cnt <= '0;
         else if (clr)         cnt <= '0;
         else if (cnt == LAST) cnt <= '0;
         else                  cnt <= cnt + 1'b1;
      end

      assign tick = (cnt == LAST);
   end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
   import cfgl_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int HALF_CLKS   = 2,
   parameter int WAIT_CLKS   = 2_500_000,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  byte_total,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   output logic              dev_prog_n,
   output logic              dev_cclk,
   output logic              dev_din,
   input  logic              dev_init_n,
   input  logic              dev_done,
   output logic              busy,
   output logic              done,
   output logic [2:0]        err_code
);
   localparam int            TW      = $clog2(WAIT_CLKS + 1);
   localparam logic [TW-1:0] T_LIMIT = TW'(WAIT_CLKS);
   localparam int            BIW     = $clog2(BYTE_W);

   if (CNT_W < 1) begin : g_bad_cnt
      $error("cfg_serial_loader: CNT_W must be at least 1");
   end
   if (WAIT_CLKS < 2) begin : g_bad_wait
      $error("cfg_serial_loader: WAIT_CLKS must be at least 2");
   end

   cfgl_state_e       state_q;
   cfgl_err_e         err_q;
   logic [TW-1:0]     tmr_q;
   logic [CNT_W-1:0]  left_q;
   logic [BIW-1:0]    bit_q;
   logic [BYTE_W-2:0] sh_q;
   logic              prog_n_q, cclk_q, din_q, busy_q, done_q;
   logic [1:0]        pins_s;
   logic              init_hi, done_hi, tmr_exp, crc_hit, tick, tick_clr;

   cfgl_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({dev_init_n, dev_done}),
      .q     (pins_s)
   );
   assign init_hi = pins_s[1];
   assign done_hi = pins_s[0];

   assign tick_clr = (state_q != S_SHIFT) && (state_q != S_TRAIL);

   cfgl_tick #(.HALF_CLKS(HALF_CLKS)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tick_clr),
      .tick  (tick)
   );

   assign tmr_exp = (tmr_q == T_LIMIT);
   assign crc_hit = !init_hi && !done_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         err_q    <= ERR_NONE;
         tmr_q    <= '0;
         left_q   <= '0;
         bit_q    <= '0;
         sh_q     <= '0;
         prog_n_q <= 1'b1;
         cclk_q   <= 1'b0;
         din_q    <= 1'b1;
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         if (!tmr_exp) tmr_q <= tmr_q + 1'b1;
         unique case (state_q)
            S_IDLE: if (start) begin
               done_q   <= 1'b0;
               err_q    <= ERR_NONE;
               busy_q   <= 1'b1;
               prog_n_q <= 1'b0;
               left_q   <= byte_total;
               tmr_q    <= '0;
               state_q  <= S_PROG;
            end
            S_PROG: if (!init_hi) begin
               prog_n_q <= 1'b1;
               tmr_q    <= '0;
               state_q  <= S_WAKE;
            end else if (tmr_exp) begin
               err_q    <= ERR_INIT_START;
               busy_q   <= 1'b0;
               prog_n_q <= 1'b1;
               state_q  <= S_IDLE;
            end
            S_WAKE: if (init_hi) begin
               tmr_q   <= '0;
               state_q <= (left_q == '0) ? S_TRAIL : S_GATE;
            end else if (tmr_exp) begin
               err_q   <= ERR_INIT_CLEAR;
               busy_q  <= 1'b0;
               state_q <= S_IDLE;
            end
            S_GATE: if (crc_hit) begin
               err_q   <= ERR_CRC;
               busy_q  <= 1'b0;
               din_q   <= 1'b1;
               state_q <= S_IDLE;
            end else if (in_valid) begin
               sh_q    <= in_data[BYTE_W-2:0];
               din_q   <= in_data[BYTE_W-1];
               cclk_q  <= 1'b0;
               bit_q   <= BIW'(BYTE_W - 1);
               state_q <= S_SHIFT;
            end
            S_SHIFT: if (tick) begin
               if (!cclk_q) begin
                  cclk_q <= 1'b1;
               end else begin
                  cclk_q <= 1'b0;
                  if (bit_q == '0) begin
                     left_q <= left_q - 1'b1;
                     if (left_q == CNT_W'(1)) begin
                        din_q   <= 1'b1;
                        tmr_q   <= '0;
                        state_q <= S_TRAIL;
                     end else begin
                        state_q <= S_GATE;
                     end
                  end else begin
                     bit_q <= bit_q - 1'b1;
                     din_q <= sh_q[BYTE_W-2];
                     sh_q  <= {sh_q[BYTE_W-3:0], 1'b0};
                  end
               end
            end
            S_TRAIL: if (done_hi) begin
               done_q  <= 1'b1;
               busy_q  <= 1'b0;
               cclk_q  <= 1'b0;
               state_q <= S_IDLE;
            end else if (tmr_exp) begin
               err_q   <= ERR_DONE_TMO;
               busy_q  <= 1'b0;
               cclk_q  <= 1'b0;
               state_q <= S_IDLE;
            end else if (tick) begin
               cclk_q <= ~cclk_q;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign in_ready   = (state_q == S_GATE) && !crc_hit;
   assign dev_prog_n = prog_n_q;
   assign dev_cclk   = cclk_q;
   assign dev_din    = din_q;
   assign busy       = busy_q;
   assign done       = done_q;
   assign err_code   = err_q;
endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker #(
   parameter int HALF_CLKS = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       busy,
   input logic       done,
   input logic [2:0] err_code,
   input logic       dev_prog_n,
   input logic       dev_cclk,
   input logic       in_ready,
   input logic       in_valid
);
   localparam int            RW   = $clog2(HALF_CLKS + 2) + 1;
   localparam logic [RW-1:0] RMAX = '1;

   logic [RW-1:0] run;
   logic          cclk_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run       <= '0;
         cclk_seen <= 1'b0;
      end else begin
         cclk_seen <= dev_cclk;
         if (dev_cclk != cclk_seen) run <= RW'(1);
         else if (run != RMAX)      run <= run + 1'b1;
      end
   end

   p_prog_in_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_prog_n |-> busy);

   p_quiet_in_prog_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_prog_n |-> (!dev_cclk && !in_ready));

   p_high_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dev_cclk) && busy) |-> (run == RW'(HALF_CLKS)));

   p_ready_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (!dev_cclk && busy && dev_prog_n));

   p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && in_valid) |=> !in_ready);

   p_done_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && err_code == 3'd0 && dev_prog_n));

   p_err_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (err_code != 3'd0) |-> (!busy && !done));

   p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(done) && $stable(err_code)));
endmodule

bind cfg_serial_loader cfgl_checker #(.HALF_CLKS(HALF_CLKS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .busy       (busy),
   .done       (done),
   .err_code   (err_code),
   .dev_prog_n (dev_prog_n),
   .dev_cclk   (dev_cclk),
   .in_ready   (in_ready),
   .in_valid   (in_valid)
);

// File: tb/cfg_serial_loader_bench.sv
`timescale 1ns/1ps
module cfg_serial_loader_bench;
   localparam int CNT_W = 8;
   localparam int HALF  = 2;
   localparam int WAITC = 400;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [CNT_W-1:0] byte_total = '0;
   logic [7:0] in_data = '0;
   logic in_valid = 1'b0;
   logic in_ready, dev_prog_n, dev_cclk, dev_din, busy, done;
   logic dev_init_n = 1'b1;
   logic dev_done = 1'b0;
   logic [2:0] err_code;

   always #2 clk = ~clk;

   cfg_serial_loader #(.CNT_W(CNT_W), .HALF_CLKS(HALF), .WAIT_CLKS(WAITC), .SYNC_STAGES(2))
   u_cfg_serial_loader (
      .clk(clk), .rst_n(rst_n), .start(start), .byte_total(byte_total),
      .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
      .dev_prog_n(dev_prog_n), .dev_cclk(dev_cclk), .dev_din(dev_din),
      .dev_init_n(dev_init_n), .dev_done(dev_done),
      .busy(busy), .done(done), .err_code(err_code)
   );

   int n_total = 0;
   int n_fail  = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // device model configuration and observations
   bit m_no_init, m_stuck, m_no_done;
   int m_crc_after, m_trail, exp_n;
   logic [7:0] rx_mem [32];
   logic [7:0] acc;
   int rx_n, bits, trail, trail_bad, rel_dly, hi_run, hi_bad, early, ready_bad;
   bit crc_fired, released;
   logic cclk_d = 1'b0;

   // stream source
   logic [7:0] src [32];
   int src_n, idx;
   bit feed_on, hs_pend;

   task automatic model_step();
      if (!dev_prog_n) begin
         dev_init_n = m_no_init;
         dev_done   = 1'b0;
         rx_n = 0; bits = 0; trail = 0; trail_bad = 0;
         crc_fired = 0; released = 0; rel_dly = 6; hi_run = 0; hi_bad = 0; early = 0;
      end else begin
         if (!dev_init_n && !crc_fired && !m_stuck && !released) begin
            if (rel_dly == 0) begin dev_init_n = 1'b1; released = 1; end
            else rel_dly--;
         end
         if (dev_cclk && !cclk_d) begin
            if (!released) early++;
            if (rx_n < exp_n) begin
               acc = {acc[6:0], dev_din};
               bits++;
               if (bits == 8) begin
                  rx_mem[rx_n] = acc;
                  rx_n++;
                  bits = 0;
                  if (rx_n == m_crc_after) begin crc_fired = 1; dev_init_n = 1'b0; end
               end
            end else begin
               trail++;
               if (!dev_din) trail_bad++;
               if (trail >= m_trail && !m_no_done) dev_done = 1'b1;
            end
         end
         if (dev_cclk) hi_run++;
         else begin
            if (cclk_d && busy && hi_run != HALF) hi_bad++;
            hi_run = 0;
         end
      end
      if (in_ready && dev_cclk) ready_bad++;
      cclk_d = dev_cclk;
   endtask

   task automatic feed_step();
      if (hs_pend) begin idx++; in_valid = 1'b0; end
      if (feed_on && idx < src_n) begin
         if (!in_valid) in_valid = ($urandom % 4) != 0;
         in_data = src[idx];
      end else begin
         in_valid = 1'b0;
      end
      hs_pend = in_valid && in_ready;
   endtask

   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            model_step();
            feed_step();
         end
      end
   end

   function automatic int exp_code(bit no_init, bit stuck, int crc_after, bit no_done);
      if (no_init) return 1;
      if (stuck) return 2;
      if (crc_after > 0) return 3;
      if (no_done) return 4;
      return 0;
   endfunction

   task automatic run_load(input int n, input int trl, input bit no_init, input bit stuck,
                           input int crc_after, input bit no_done, input bit restart_mid,
                           input string tag);
      int e, bad, c;
      m_no_init = no_init; m_stuck = stuck; m_crc_after = crc_after;
      m_no_done = no_done; m_trail = trl; exp_n = n;
      src_n = n; idx = 0; hs_pend = 0; ready_bad = 0; feed_on = 1;
      byte_total = CNT_W'(n);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy && !dev_prog_n, "R2", {tag, " program asserted after start"}, int'(dev_prog_n), 0);
      chk(err_code == 3'd0 && !done, "R12", {tag, " flags cleared by start"}, int'(err_code), 0);
      if (restart_mid) begin
         repeat (40) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      c = 0;
      while (busy && c < 20000) begin @(negedge clk); c++; end
      e = exp_code(no_init, stuck, crc_after, no_done);
      case (e)
         1: chk(err_code == 3'd1, "R3", {tag, " init-start timeout"}, int'(err_code), e);
         2: chk(err_code == 3'd2, "R4", {tag, " init-clear timeout"}, int'(err_code), e);
         3: chk(err_code == 3'd3, "R9", {tag, " crc fault code"}, int'(err_code), e);
         4: chk(err_code == 3'd4, "R11", {tag, " done timeout"}, int'(err_code), e);
         default: chk(err_code == 3'd0 && done, "R10", {tag, " done reported"}, int'(err_code), 0);
      endcase
      if (e == 0) begin
         bad = 0;
         for (int i = 0; i < n; i++) if (rx_mem[i] !== src[i]) bad++;
         chk(rx_n == n && bad == 0, "R6", {tag, " bytes received msb first"}, bad + (n - rx_n), 0);
         chk(trail_bad == 0 && trail >= trl, "R10", {tag, " trailing data high"}, trail_bad, 0);
         chk(hi_bad == 0, "R7", {tag, " clock high phase length"}, hi_bad, 0);
         chk(early == 0 && ready_bad == 0, "R5", {tag, " no early clocks"}, early + ready_bad, 0);
         chk(idx == n, "R8", {tag, " bytes accepted"}, idx, n);
      end else begin
         chk(!done && dev_prog_n && !busy, "R12", {tag, " idle after error"}, int'(done), 0);
         if (e == 3) chk(rx_n < n, "R9", {tag, " load stopped early"}, rx_n, n - 1);
      end
      if (restart_mid) begin
         repeat (10) @(negedge clk);
         chk(!busy && done, "R12", {tag, " start during load ignored"}, int'(busy), 0);
      end
      feed_on = 0;
      in_valid = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   initial begin
      int n;
      void'($urandom(32'd20240611));
      m_crc_after = 0; exp_n = 0; m_trail = 1;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dev_prog_n && !dev_cclk && !busy && !done && !in_ready && err_code == 3'd0,
          "R1", "reset state", int'(err_code), 0);

      // directed: single byte with mixed bits
      src[0] = 8'hA5;
      run_load(1, 3, 0, 0, 0, 0, 0, "one byte");
      // directed: extreme patterns to expose bit order
      src[0] = 8'h80; src[1] = 8'h01; src[2] = 8'h00; src[3] = 8'hFF;
      run_load(4, 2, 0, 0, 0, 0, 0, "edge patterns");
      // directed: empty bitstream, trailing clocks only
      run_load(0, 4, 0, 0, 0, 0, 0, "empty");
      // random loads, one with a start pulse mid-load
      for (int k = 0; k < 4; k++) begin
         n = 4 + int'($urandom % 9);
         for (int i = 0; i < n; i++) src[i] = 8'($urandom);
         run_load(n, 1 + int'($urandom % 10), 0, 0, 0, 0, k == 1, "random");
      end
      // failure phases
      run_load(3, 2, 1, 0, 0, 0, 0, "no init");
      run_load(3, 2, 0, 1, 0, 0, 0, "init stuck");
      for (int i = 0; i < 6; i++) src[i] = 8'($urandom);
      run_load(6, 2, 0, 0, 2, 0, 0, "crc");
      run_load(2, 2, 0, 0, 0, 1, 0, "no done");
      // error cleared by a good load
      src[0] = 8'h3C; src[1] = 8'hC3;
      run_load(2, 2, 0, 0, 0, 0, 0, "recover");
      repeat (20) @(negedge clk);
      chk(done && err_code == 3'd0, "R12", "done held while idle", int'(done), 1);

      finished = 1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_total++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end
endmodule